// File: doc/BRIEF.md
# Dual-Lane Instruction Bundle Dispatcher

This block sits at the front of a statically scheduled, wide-issue core. Each cycle it takes up to two 128-bit instruction bundles, one per input lane. It cuts every bundle into a 5-bit template and three 41-bit instruction slots. It looks the template up to find which execution-unit class each slot belongs to, and hands all slots to registered per-slot issue outputs. Each slot output carries its unit class and a valid bit, so up to six instructions leave the block in one cycle. The block does not decode opcodes, read registers or model execution. It only classifies slots and times their issue.

Two templates carry a long immediate. In those bundles the second and third slots together form one extended instruction. The block issues that pair as a single instruction on the second slot, marks the lane as paired, and keeps the third slot's bits alongside without a valid bit. A template code missing from the table is reported as illegal. Such a bundle is consumed, but none of its slots issue. Lanes issue strictly in order: a later lane is accepted only together with every earlier lane. One downstream ready signal stalls all lanes at once.

Top module: `bundle_dispatch`

## Requirements
- R1: For each accepted bundle, the template is bits [4:0]. Slot s (s = 0, 1, 2) is bits [5+41*s +: 41]. Slot s of lane k appears on `out_slot_insn[(3*k+s)*41 +: 41]` without change.
- R2: Unit codes are M=0, I=1, F=2, B=3, L=4, X=5. The template sets the classes of slots 0/1/2 as follows: 0–3 MII, 8–11 MMI, 12–13 MFI, 14–15 MMF, 16–17 MIB, 18–19 MBB, 22–23 BBB, 24–25 MMB, 28–29 MFB. For these templates all three slot valids are set. The class of slot s of lane k is on `out_slot_unit[(3*k+s)*3 +: 3]`, and its valid bit is `out_slot_valid[3*k+s]`.
- R3: Templates 4–5 (long immediate) issue slot 0 as M and slot 1 as L, with `out_pair` set. Slot 2 is reported with unit X but with its valid bit clear.
- R4: Templates 6, 7, 20, 21, 26, 27, 30 and 31 are accepted and raise `out_illegal` for that lane. None of their slot valids is set, and `out_pair` stays clear.
- R5: `in_ready[0]` equals `out_ready`. `in_ready[k]` for k>0 equals `out_ready` ANDed with `in_valid` of every lower lane, so a lane is never accepted without all earlier lanes.
- R6: A bundle accepted at a clock edge (valid and ready both high) shows on the lane's outputs right after that same edge, with `out_bundle_valid` set. The latency is one register stage.
- R7: While `out_ready` is low, every output register keeps its value and no bundle is accepted.
- R8: When `out_ready` is high and a lane accepts nothing at an edge, that lane's bundle valid, slot valids, illegal and pair outputs are low after the edge.
- R9: During and right after a synchronous active-low reset, every valid, illegal and pair output is low.
- R10: Both lanes decode and issue independently in the same cycle, for up to six valid slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | NUM_LANES | Bundle present, one bit per lane |
| in_ready | output | NUM_LANES | Lane may be accepted this cycle |
| in_bundle | input | NUM_LANES*128 | Bundles, lane k at bits [128*k +: 128] |
| out_ready | input | 1 | Downstream takes a new issue group |
| out_bundle_valid | output | NUM_LANES | Lane holds an accepted bundle |
| out_illegal | output | NUM_LANES | Lane's bundle had a reserved template |
| out_pair | output | NUM_LANES | Lane's slots 1 and 2 form one extended instruction |
| out_slot_valid | output | NUM_LANES*3 | Per-slot issue valid |
| out_slot_unit | output | NUM_LANES*9 | Per-slot 3-bit unit class |
| out_slot_insn | output | NUM_LANES*123 | Per-slot 41-bit instruction |

## Verification
The hardest state to reach from the ports is a later lane offering a bundle while an earlier lane is idle. A second hard case is new bundles arriving during a stall, where they must neither be taken nor disturb the held outputs. The stimulus builds both cases on purpose. It raises only lane 1's valid and checks both the ready vector and the empty result. It then holds `out_ready` low for several cycles while changing both bundles every cycle. Besides this, all 32 template codes are swept on lane 0 while lane 1 carries a differently permuted template in the same cycle. Every legal, paired and illegal code therefore meets every other class side by side.

// File: rtl/bdisp_pkg.sv
// Package: shared widths and types for the bundle dispatcher.
// Assumes a fixed 128-bit bundle of one 5-bit template and three 41-bit slots.
package bdisp_pkg;
    localparam int BUNDLE_W = 128;
    localparam int TMPL_W   = 5;
    localparam int SLOT_W   = 41;
    localparam int SLOTS    = 3;
    localparam int UNIT_W   = 3;

    typedef enum logic [UNIT_W-1:0] {
        UNIT_M    = 3'd0,
        UNIT_I    = 3'd1,
        UNIT_F    = 3'd2,
        UNIT_B    = 3'd3,
        UNIT_L    = 3'd4,
        UNIT_X    = 3'd5,
        UNIT_NONE = 3'd7
    } unit_e;

    typedef struct packed {
        logic  legal;
        logic  pair;
        unit_e u2;
        unit_e u1;
        unit_e u0;
    } tmpl_info_t;
endpackage

// File: rtl/bdisp_tmpl_decode.sv
// Module: template decoder. Maps a 5-bit template to per-slot unit classes.
// Assumes the template's low bit only marks a stop and never changes the units.
module bdisp_tmpl_decode
    import bdisp_pkg::*;
(
    input  logic [TMPL_W-1:0] tmpl,
    output tmpl_info_t        info
);
    // Table lookup on the four upper template bits.
    always_comb begin
        info = '{legal: 1'b1, pair: 1'b0, u2: UNIT_NONE, u1: UNIT_NONE, u0: UNIT_NONE};
        unique case (tmpl[4:1])
            4'b0000, 4'b0001: {info.u0, info.u1, info.u2} = {UNIT_M, UNIT_I, UNIT_I};
            4'b0010: begin
                {info.u0, info.u1, info.u2} = {UNIT_M, UNIT_L, UNIT_X};
                info.pair = 1'b1;
            end
            4'b0100, 4'b0101: {info.u0, info.u1, info.u2} = {UNIT_M, UNIT_M, UNIT_I};
            4'b0110: {info.u0, info.u1, info.u2} = {UNIT_M, UNIT_F, UNIT_I};
            4'b0111: {info.u0, info.u1, info.u2} = {UNIT_M, UNIT_M, UNIT_F};
            4'b1000: {info.u0, info.u1, info.u2} = {UNIT_M, UNIT_I, UNIT_B};
            4'b1001: {info.u0, info.u1, info.u2} = {UNIT_M, UNIT_B, UNIT_B};
            4'b1011: {info.u0, info.u1, info.u2} = {UNIT_B, UNIT_B, UNIT_B};
            4'b1100: {info.u0, info.u1, info.u2} = {UNIT_M, UNIT_M, UNIT_B};
            4'b1110: {info.u0, info.u1, info.u2} = {UNIT_M, UNIT_F, UNIT_B};
            default: info.legal = 1'b0;
        endcase
    end

    // Reserved codes never yield a paired or classified slot (R4).
    always_comb begin
        if (!info.legal) begin
            a_illegal_clean_r4: assert (!info.pair && info.u0 == UNIT_NONE);
        end
    end
endmodule

// File: rtl/bdisp_lane_split.sv
// Module: single-lane splitter. Cuts one bundle into slots and attaches
// each slot's unit class and issue valid. Purely combinational.
// Assumes slot 0 sits directly above the template, slot 2 at the top.
module bdisp_lane_split
    import bdisp_pkg::*;
(
    input  logic [BUNDLE_W-1:0]        bundle,
    output logic [SLOTS*SLOT_W-1:0]    insn,
    output logic [SLOTS*UNIT_W-1:0]    unit,
    output logic [SLOTS-1:0]           slot_valid,
    output logic                       pair,
    output logic                       illegal
);
    tmpl_info_t info;

    bdisp_tmpl_decode u_dec (
        .tmpl (bundle[TMPL_W-1:0]),
        .info (info)
    );

    // Slot extraction: fixed bit fields above the template.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign insn[s*SLOT_W +: SLOT_W] = bundle[TMPL_W + s*SLOT_W +: SLOT_W];
    end

    // Classification outputs; the paired upper slot never issues on its own.
    assign unit       = {info.u2, info.u1, info.u0};
    assign slot_valid = {info.legal & ~info.pair, info.legal, info.legal};
    assign pair       = info.pair;
    assign illegal    = ~info.legal;
endmodule

// File: rtl/bdisp_issue_reg.sv
// Module: issue register. One load-enabled stage that holds the whole
// issue group while downstream stalls.
// Assumes the caller has already masked valid bits for lanes not accepted.
module bdisp_issue_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture a new issue group only when downstream takes one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load_en)
            q <= d;
    end

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(q));
endmodule

// File: rtl/bundle_dispatch.sv
// Module: bundle dispatcher top. Accepts up to NUM_LANES bundles per cycle
// in lane order, classifies every slot by template and registers the result.
// Assumes one downstream ready covers all lanes; lane readiness depends on
// the valids of earlier lanes within the same cycle.
module bundle_dispatch
    import bdisp_pkg::*;
#(
    parameter int NUM_LANES = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_LANES-1:0]               in_valid,
    output logic [NUM_LANES-1:0]               in_ready,
    input  logic [NUM_LANES*BUNDLE_W-1:0]      in_bundle,
    input  logic                               out_ready,
    output logic [NUM_LANES-1:0]               out_bundle_valid,
    output logic [NUM_LANES-1:0]               out_illegal,
    output logic [NUM_LANES-1:0]               out_pair,
    output logic [NUM_LANES*SLOTS-1:0]         out_slot_valid,
    output logic [NUM_LANES*SLOTS*UNIT_W-1:0]  out_slot_unit,
    output logic [NUM_LANES*SLOTS*SLOT_W-1:0]  out_slot_insn
);
    localparam int SV_W   = NUM_LANES*SLOTS;
    localparam int UN_W   = NUM_LANES*SLOTS*UNIT_W;
    localparam int IN_W   = NUM_LANES*SLOTS*SLOT_W;
    localparam int REG_W  = 3*NUM_LANES + SV_W + UN_W + IN_W;

    logic [NUM_LANES-1:0] accept;
    logic [NUM_LANES-1:0] nxt_bv, nxt_ill, nxt_pair;
    logic [SV_W-1:0]      nxt_sv;
    logic [UN_W-1:0]      nxt_unit;
    logic [IN_W-1:0]      nxt_insn;
    logic [REG_W-1:0]     reg_d, reg_q;

    // In-order readiness: a lane is ready only if every earlier lane is valid.
    always_comb begin
        logic prior;
        prior = 1'b1;
        for (int k = 0; k < NUM_LANES; k++) begin
            in_ready[k] = out_ready & prior;
            prior       = prior & in_valid[k];
        end
    end

    assign accept = in_valid & in_ready;

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        logic [SLOTS*SLOT_W-1:0] l_insn;
        logic [SLOTS*UNIT_W-1:0] l_unit;
        logic [SLOTS-1:0]        l_sv;
        logic                    l_pair, l_ill;

        bdisp_lane_split u_split (
            .bundle     (in_bundle[k*BUNDLE_W +: BUNDLE_W]),
            .insn       (l_insn),
            .unit       (l_unit),
            .slot_valid (l_sv),
            .pair       (l_pair),
            .illegal    (l_ill)
        );

        // Mask every per-lane flag with acceptance; data passes unmasked.
        assign nxt_bv[k]                              = accept[k];
        assign nxt_ill[k]                             = accept[k] & l_ill;
        assign nxt_pair[k]                            = accept[k] & l_pair;
        assign nxt_sv[k*SLOTS +: SLOTS]               = l_sv & {SLOTS{accept[k]}};
        assign nxt_unit[k*SLOTS*UNIT_W +: SLOTS*UNIT_W] = l_unit;
        assign nxt_insn[k*SLOTS*SLOT_W +: SLOTS*SLOT_W] = l_insn;

        p_illegal_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
            out_illegal[k] |-> (out_slot_valid[k*SLOTS +: SLOTS] == '0) && !out_pair[k]);

        p_pair_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
            out_pair[k] |-> (out_slot_valid[k*SLOTS +: SLOTS] == 3'b011)
                && (out_slot_unit[(k*SLOTS+1)*UNIT_W +: UNIT_W] == UNIT_L)
                && (out_slot_unit[(k*SLOTS+2)*UNIT_W +: UNIT_W] == UNIT_X));

        p_accept_shows_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid[k] && in_ready[k]) |=> out_bundle_valid[k]);

        p_slot_needs_bundle_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (out_slot_valid[k*SLOTS +: SLOTS] != '0) |-> out_bundle_valid[k]);

        if (k > 0) begin : g_order
            p_lane_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
                out_bundle_valid[k] |-> out_bundle_valid[k-1]);
        end
    end

    assign reg_d = {nxt_bv, nxt_ill, nxt_pair, nxt_sv, nxt_unit, nxt_insn};

    bdisp_issue_reg #(.W(REG_W)) u_issue (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (out_ready),
        .d       (reg_d),
        .q       (reg_q)
    );

    assign {out_bundle_valid, out_illegal, out_pair,
            out_slot_valid, out_slot_unit, out_slot_insn} = reg_q;

    p_stall_no_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |-> (in_ready == '0));
endmodule

// File: tb/bundle_dispatch_tb_top.sv
module bundle_dispatch_tb_top;
    localparam int NL = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NL-1:0]   in_valid;
    logic [NL-1:0]   in_ready;
    logic [NL*128-1:0] in_bundle;
    logic            out_ready;
    logic [NL-1:0]   out_bundle_valid, out_illegal, out_pair;
    logic [NL*3-1:0] out_slot_valid;
    logic [NL*9-1:0] out_slot_unit;
    logic [NL*123-1:0] out_slot_insn;

    bundle_dispatch #(.NUM_LANES(NL)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_bundle(in_bundle), .out_ready(out_ready),
        .out_bundle_valid(out_bundle_valid), .out_illegal(out_illegal),
        .out_pair(out_pair), .out_slot_valid(out_slot_valid),
        .out_slot_unit(out_slot_unit), .out_slot_insn(out_slot_insn)
    );

    always #10 clk = ~clk;   // 50 MHz

    int n_checks = 0;
    int n_fail   = 0;
    logic [63:0] seed = 64'h1234_5678_9abc_def1;

    // Expected state of the output register.
    logic [NL-1:0]   e_bv, e_ill, e_pair;
    logic [NL*3-1:0] e_sv;
    logic [2:0]      e_unit [NL*3];
    logic [40:0]     e_insn [NL*3];

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Template table from the requirement ranges: {legal, pair, u0, u1, u2}.
    function automatic logic [10:0] tmpl_exp(input int t);
        logic [2:0] M = 3'd0, I = 3'd1, F = 3'd2, B = 3'd3, L = 3'd4, X = 3'd5, N = 3'd7;
        if (t <= 3)       return {2'b10, M, I, I};
        else if (t <= 5)  return {2'b11, M, L, X};
        else if (t <= 7)  return {2'b00, N, N, N};
        else if (t <= 11) return {2'b10, M, M, I};
        else if (t <= 13) return {2'b10, M, F, I};
        else if (t <= 15) return {2'b10, M, M, F};
        else if (t <= 17) return {2'b10, M, I, B};
        else if (t <= 19) return {2'b10, M, B, B};
        else if (t <= 21) return {2'b00, N, N, N};
        else if (t <= 23) return {2'b10, B, B, B};
        else if (t <= 25) return {2'b10, M, M, B};
        else if (t <= 27) return {2'b00, N, N, N};
        else if (t <= 29) return {2'b10, M, F, B};
        else              return {2'b00, N, N, N};
    endfunction

    function automatic logic [40:0] rnd41();
        seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
        return seed[63:23];
    endfunction

    function automatic logic [127:0] make_bundle(input int t);
        logic [40:0] s0, s1, s2;
        s0 = rnd41(); s1 = rnd41(); s2 = rnd41();
        return {s2, s1, s0, t[4:0]};
    endfunction

    // Drive at negedge, check readiness, update model at edge, check at next negedge.
    task automatic step(input logic [NL-1:0] v, input logic [NL*128-1:0] b, input logic ordy);
        logic [NL-1:0] exp_rdy;
        in_valid = v; in_bundle = b; out_ready = ordy;
        #1;
        exp_rdy[0] = ordy;
        for (int k = 1; k < NL; k++) exp_rdy[k] = exp_rdy[k-1] & v[k-1];
        check("R5 in_ready", in_ready, exp_rdy);
        if (ordy) begin
            for (int k = 0; k < NL; k++) begin
                logic acc;
                logic [10:0] ti;
                acc = v[k] & exp_rdy[k];
                ti  = tmpl_exp(int'(b[k*128 +: 5]));
                e_bv[k]   = acc;
                e_ill[k]  = acc & ~ti[10];
                e_pair[k] = acc & ti[9];
                for (int s = 0; s < 3; s++) begin
                    e_sv[k*3+s] = acc & ti[10] & !(s == 2 && ti[9]);
                    e_unit[k*3+s] = ti[(2-s)*3 +: 3];
                    e_insn[k*3+s] = b[k*128 + 5 + 41*s +: 41];
                end
            end
        end
        @(negedge clk);
        for (int k = 0; k < NL; k++) begin
            check($sformatf("R6 lane%0d bundle valid", k), out_bundle_valid[k], e_bv[k]);
            check($sformatf("R4 lane%0d illegal", k), out_illegal[k], e_ill[k]);
            check($sformatf("R3 lane%0d pair", k), out_pair[k], e_pair[k]);
            check($sformatf("R2 R8 lane%0d slot valids", k), out_slot_valid[k*3 +: 3], e_sv[k*3 +: 3]);
            for (int s = 0; s < 3; s++) begin
                if (e_sv[k*3+s] || (s == 2 && e_pair[k])) begin
                    check($sformatf("R2 lane%0d slot%0d unit", k, s),
                          out_slot_unit[(k*3+s)*3 +: 3], e_unit[k*3+s]);
                    check($sformatf("R1 lane%0d slot%0d insn", k, s),
                          out_slot_insn[(k*3+s)*41 +: 41], e_insn[k*3+s]);
                end
            end
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        logic [NL*128-1:0] b;
        rst_n = 1'b0; in_valid = '0; in_bundle = '0; out_ready = 1'b1;
        e_bv = '0; e_ill = '0; e_pair = '0; e_sv = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 bundle valid", out_bundle_valid, 0);
        check("R9 slot valid", out_slot_valid, 0);
        check("R9 illegal/pair", {out_illegal, out_pair}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 after release", {out_bundle_valid, out_slot_valid}, 0);

        // R1 R2 R3 R4 R10: every template on lane 0 with a permuted one on lane 1
        for (int t = 0; t < 32; t++) begin
            b = {make_bundle((t*7 + 3) % 32), make_bundle(t)};
            step(2'b11, b, 1'b1);
        end
        // Lane 1 sweep with lane 0 fixed on a legal code
        for (int t = 0; t < 32; t++) begin
            b = {make_bundle(t), make_bundle(16)};
            step(2'b11, b, 1'b1);
        end

        // R5: lane 1 offered while lane 0 idle, nothing taken
        b = {make_bundle(0), make_bundle(0)};
        step(2'b10, b, 1'b1);
        // Lane 0 only
        b = {make_bundle(4), make_bundle(4)};
        step(2'b01, b, 1'b1);

        // R7: load a group, then stall with changing bundles
        b = {make_bundle(29), make_bundle(5)};
        step(2'b11, b, 1'b1);
        for (int i = 0; i < 4; i++) begin
            b = {make_bundle(i + 8), make_bundle(31 - i)};
            step(2'b11, b, 1'b0);   // R7 model unchanged
        end

        // R8: ready with nothing offered clears the group
        step(2'b00, b, 1'b1);

        // R9: reset mid-stream clears outputs
        b = {make_bundle(1), make_bundle(2)};
        step(2'b11, b, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 mid reset", {out_bundle_valid, out_slot_valid, out_illegal, out_pair}, 0);
        rst_n = 1'b1;

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule